// File: doc/BRIEF.md
# Page-Buffered Write Committer

This block sits behind the byte decoder of a serial memory and turns one write transaction into writes to a 128x8 array. Data bytes arrive on a valid/ready stream and go into a 16-slot page buffer. The first byte accepted in a transaction takes its address from `start_addr`. Each later byte goes to the next slot. Only the low four address bits advance, so a long write wraps back to the start of the same 16-byte page and overwrites the older bytes. The upper three address bits stay fixed for the whole transaction.

A `stop_strobe` closes the transaction. The block then drains the slots that hold data to the memory write port, one byte per clock, in ascending slot order. After that a write-cycle timer runs for `WRITE_CYCLES` clocks. `busy` is high from the cycle after the Stop until the timer expires. While `busy` is high, `byte_ready` is low. A byte offered during that time is not taken, and a Stop during that time has no effect.

Back-pressure rules: a byte is accepted on a rising edge where `byte_valid` and `byte_ready` are both high. The source may hold `byte_valid` high while `byte_ready` is low, and must keep `byte_data` stable until the byte is accepted. `start_addr` is used only for the first byte after an idle, empty buffer. When `wp_pin` is high, writes into the upper half of the array (address bit 6 set) are dropped silently. The timer still runs in full.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset `busy` is 0, `mem_we` is 0 and `byte_ready` is 1.
- R2: The first accepted byte of a transaction goes to address `start_addr`. Each later byte goes to an address whose bits [3:0] are one higher modulo 16 and whose bits [6:4] are unchanged, so the write wraps within the page. `start_addr` is ignored for every byte after the first.
- R3: When more than 16 bytes are accepted before the Stop, each slot commits the last byte written to it, so only the final 16 bytes reach the array.
- R4: No memory write happens before the Stop. The first commit write appears in the cycle after the rising edge that samples `stop_strobe`. A byte accepted on that same edge is included in the commit.
- R5: Each filled slot is written exactly once, one write per clock, in consecutive cycles, in ascending order of address bits [3:0]. Slots that were never filled are not written.
- R6: When `wp_pin` is high and the page has address bit 6 set, `mem_we` stays 0 for the whole commit, and the array is unchanged.
- R7: When `wp_pin` is low, or the page has address bit 6 clear, every filled slot is written.
- R8: `busy` stays high for exactly n + WRITE_CYCLES cycles after the Stop edge, where n is the number of filled slots. This holds even when every write was blocked.
- R9: While `busy` is high, `byte_ready` is 0. Bytes and Stops offered in that time are not captured and do not affect any commit.
- R10: A Stop while idle with an empty buffer and no byte offered is ignored: `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Block can take a byte (idle) |
| byte_data | input | 8 | Data byte |
| start_addr | input | 7 | Address of first byte of the transaction |
| stop_strobe | input | 1 | End of transaction, starts the commit |
| wp_pin | input | 1 | Protect the upper half of the array when high |
| mem_addr | output | 7 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | Commit or write-cycle timer in progress |

## Verification
The bench targets wraparound from slots 14 and 15 back to 0. A design that carried into bit 4 would write the next page, and one that committed in arrival order would break the ascending write sequence. Writes longer than 16 bytes check that each slot commits its newest byte rather than its first. Protected-page writes check that `mem_we` stays low while `busy` still lasts the full n + WRITE_CYCLES cycles. Other directed cases cover a byte arriving together with the Stop, a Stop on an empty buffer, and stimulus offered during `busy`. A design that accepted those inputs would commit extra data or stay busy longer than it should.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COMMIT = 2'd1,
    ST_WAIT   = 2'd2
  } wstate_t;
endpackage

// File: rtl/pgw_page_buffer.sv
module pgw_page_buffer #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SLOT_W = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  take,
  input  logic [ADDR_W-1:0]                     start_addr,
  input  logic [DATA_W-1:0]                     wdata,
  input  logic [(1<<SLOT_W)-1:0]                drain,
  output logic [ADDR_W-SLOT_W-1:0]              page,
  output logic [(1<<SLOT_W)-1:0]                mask,
  output logic [(1<<SLOT_W)-1:0][DATA_W-1:0]    slots
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic [SLOTS-1:0]  mask_q;
  logic [SLOT_W-1:0] ptr_q;
  logic [PAGE_W-1:0] page_q;
  logic              empty;
  logic [SLOT_W-1:0] idx;
  logic [SLOTS-1:0]  fill;

  // An empty buffer means a new transaction: take the address from the port.
  assign empty = ~|mask_q;
  assign idx   = empty ? start_addr[SLOT_W-1:0] : ptr_q;
  assign fill  = take ? (SLOTS'(1) << idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
      page_q <= '0;
    end else begin
      mask_q <= (mask_q & ~drain) | fill;
      if (take) begin
        ptr_q <= SLOT_W'(idx + 1'b1);
        if (empty) page_q <= start_addr[ADDR_W-1:SLOT_W];
      end
    end
  end

  // Per-slot storage, no reset needed: only filled slots are ever read.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (take && (idx == SLOT_W'(s))) slots[s] <= wdata;
    end
  end

  assign page = page_q;
  assign mask = mask_q;

  // R5: the sequencer only drains slots that hold data
  assert_drain_filled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|drain) |-> ((drain & mask_q) == drain));
  // R5: at most one slot drained per clock
  assert_drain_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drain));
endmodule

// File: rtl/pgw_slot_picker.sv
module pgw_slot_picker #(
  parameter int SLOT_W = 4
) (
  input  logic [(1<<SLOT_W)-1:0] mask,
  output logic [(1<<SLOT_W)-1:0] pick,
  output logic [SLOT_W-1:0]      pick_idx,
  output logic                   any,
  output logic                   last
);
  localparam int SLOTS = 1 << SLOT_W;

  // Lowest set bit wins.
  assign pick = mask & (~mask + SLOTS'(1));
  assign any  = |mask;
  assign last = any && ((mask & ~pick) == '0);

  always_comb begin
    pick_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (mask[i]) pick_idx = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/pgw_commit_fsm.sv
module pgw_commit_fsm
  import pgw_pkg::*;
#(
  parameter int WRITE_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  input  logic pick_any,
  input  logic pick_last,
  output logic busy,
  output logic committing
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  wstate_t         state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (trigger) state_q <= ST_COMMIT;
        ST_COMMIT: if (pick_last) begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
        end
        ST_WAIT: begin
          if (cnt_q == CNT_W'(WRITE_CYCLES - 1)) state_q <= ST_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign committing = (state_q == ST_COMMIT);

  // R5: the commit phase always has a slot to drain
  assert_commit_has_work_R5: assert property (@(posedge clk) disable iff (!rst_n)
    committing |-> pick_any);
  // R8: the write-cycle counter never passes its limit
  assert_timer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q < CNT_W'(WRITE_CYCLES)));
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int ADDR_W       = 7,
  parameter int DATA_W       = 8,
  parameter int SLOT_W       = 4,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              stop_strobe,
  input  logic              wp_pin,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic                           take;
  logic                           trigger;
  logic                           committing;
  logic [PAGE_W-1:0]              page;
  logic [SLOTS-1:0]               mask;
  logic [SLOTS-1:0][DATA_W-1:0]   slots;
  logic [SLOTS-1:0]               pick;
  logic [SLOTS-1:0]               drain;
  logic [SLOT_W-1:0]              pick_idx;
  logic                           pick_any;
  logic                           pick_last;
  logic                           locked;

  assign byte_ready = !busy;
  assign take       = byte_valid && byte_ready;
  // Stop closes a transaction only when something was (or is being) buffered.
  assign trigger    = !busy && stop_strobe && (take || (|mask));
  assign drain      = committing ? pick : '0;
  // Protected region: upper half of the array.
  assign locked     = wp_pin && page[PAGE_W-1];

  pgw_page_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .take(take), .start_addr(start_addr),
    .wdata(byte_data), .drain(drain), .page(page), .mask(mask), .slots(slots)
  );

  pgw_slot_picker #(.SLOT_W(SLOT_W)) u_pick (
    .mask(mask), .pick(pick), .pick_idx(pick_idx), .any(pick_any), .last(pick_last)
  );

  pgw_commit_fsm #(.WRITE_CYCLES(WRITE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .pick_any(pick_any),
    .pick_last(pick_last), .busy(busy), .committing(committing)
  );

  assign mem_we    = committing && !locked;
  assign mem_addr  = {page, pick_idx};
  assign mem_wdata = slots[pick_idx];

  // R4: memory writes only happen inside a busy period
  assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R4: a Stop with data starts the busy period on the next cycle
  assert_stop_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_strobe && (byte_valid || (|mask))) |=> busy);
  // R6: no write lands in the protected half while protection is on
  assert_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && wp_pin) |-> !mem_addr[ADDR_W-1]);
  // R9: during the timer phase the buffer is frozen and drained
  assert_wait_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !committing) |-> (mask == '0));
  // R10: an empty Stop does not start a busy period
  assert_empty_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_strobe && !byte_valid && (mask == '0)) |=> !busy);
endmodule

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
  localparam int WCYC = 20;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       byte_valid = 0;
  logic       byte_ready;
  logic [7:0] byte_data = 0;
  logic [6:0] start_addr = 0;
  logic       stop_strobe = 0;
  logic       wp_pin = 0;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic       busy;

  int checks = 0;
  int fails  = 0;

  logic [7:0] ram     [0:127];
  logic [7:0] exp_mem [0:127];

  always #5 clk = ~clk;

  page_commit_ctrl #(.WRITE_CYCLES(WCYC)) uut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .start_addr(start_addr), .stop_strobe(stop_strobe),
    .wp_pin(wp_pin), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .busy(busy)
  );

  // Simple synchronous RAM model fed from the write port.
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_locked(input logic [6:0] sa, input bit wp);
    return wp && sa[6];
  endfunction

  // One transaction: n bytes from address sa, then a Stop (optionally with the last byte).
  task automatic run_txn(input logic [6:0] sa, input int n, input bit wp, input bit stop_last);
    logic [7:0]  ebuf [0:15];
    logic [15:0] emask = '0;
    int          ord  [0:15];
    int          cnt = 0;
    wp_pin = wp;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_valid = 1;
      start_addr = (i == 0) ? sa : 7'($urandom);
      byte_data  = 8'($urandom);
      ebuf[(sa[3:0] + i) % 16] = byte_data;
      emask[(sa[3:0] + i) % 16] = 1'b1;
      if (stop_last && i == n - 1) stop_strobe = 1;
    end
    if (!stop_last) begin
      @(negedge clk);
      byte_valid  = 0;
      stop_strobe = 1;
    end
    for (int s = 0; s < 16; s++) if (emask[s]) begin ord[cnt] = s; cnt++; end
    for (int k = 1; k <= cnt + WCYC + 1; k++) begin
      @(negedge clk);
      // R9: garbage offered while busy must be ignored
      if (k <= cnt + WCYC) begin
        byte_valid  = 1'($urandom);
        stop_strobe = 1'($urandom);
        byte_data   = 8'($urandom);
        start_addr  = 7'($urandom);
      end else begin
        byte_valid  = 0;
        stop_strobe = 0;
      end
      if (k <= cnt) begin
        logic [6:0] ea;
        ea = {sa[6:4], 4'(ord[k-1])};
        if (is_locked(sa, wp)) begin
          chk(mem_we == 0, "R6 blocked write", mem_we, 0);
        end else begin
          chk(mem_we == 1, "R5/R7 write enable", mem_we, 1);
          chk(mem_addr == ea, "R2/R5 write address", mem_addr, ea);
          chk(mem_wdata == ebuf[ord[k-1]], "R3 write data", mem_wdata, ebuf[ord[k-1]]);
          exp_mem[ea] = ebuf[ord[k-1]];
        end
      end else begin
        chk(mem_we == 0, "R5 no extra write", mem_we, 0);
      end
      chk(busy == (k <= cnt + WCYC), "R8 busy length", busy, (k <= cnt + WCYC));
      chk(byte_ready == !(k <= cnt + WCYC), "R9 ready while busy", byte_ready, !(k <= cnt + WCYC));
    end
    begin
      int bad = 0;
      for (int a = 0; a < 128; a++) if (ram[a] !== exp_mem[a]) bad++;
      chk(bad == 0, "R6/R7 array contents", bad, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    for (int a = 0; a < 128; a++) begin ram[a] = 0; exp_mem[a] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(mem_we == 0, "R1 we after reset", mem_we, 0);
    chk(byte_ready == 1, "R1 ready after reset", byte_ready, 1);

    // R10: Stop with nothing buffered
    stop_strobe = 1;
    @(negedge clk);
    stop_strobe = 0;
    chk(busy == 0, "R10 empty stop ignored", busy, 0);
    @(negedge clk);
    chk(busy == 0, "R10 empty stop still idle", busy, 0);

    run_txn(7'h3E, 4, 0, 0);   // R2 wrap from slot 14 to slot 1
    run_txn(7'h05, 1, 0, 0);   // single byte write
    run_txn(7'h23, 21, 0, 0);  // R3 overflow
    run_txn(7'h50, 6, 1, 0);   // R6 protected page
    run_txn(7'h10, 5, 1, 0);   // R7 lower half writable with wp high
    run_txn(7'h77, 16, 0, 1);  // R4 byte together with Stop
    run_txn(7'h4C, 3, 0, 0);   // R7 upper half with wp low
    for (int t = 0; t < 12; t++)
      run_txn(7'($urandom), 1 + ($urandom % 40), 1'($urandom), 1'($urandom));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule